// File: doc/BRIEF.md
# Stacked-Layer Column Coincidence Filter

This block pairs hits from two sensor layers mounted a short distance apart, so that only tracks steep enough to cross nearly the same column on both layers survive. Each layer presents one event as a list on its own valid/ready stream. The first word of a list is the event time stamp. The words after it are hit column addresses in ascending order. The final word of the list is flagged as last.

The block steps through both lists in one pass, the way a merge step does. At each step it compares the current inner column with the current outer column. When the outer column lies more than the window above the inner one, the inner hit is dropped. When it lies more than the window below, the outer hit is dropped. Otherwise both hits leave together as one tracklet word, tagged with the event time stamp, and both lists advance. Once one list runs out, the rest of the other list is consumed silently. A marker word then closes the event. When the two time stamps disagree, the block pulses an error flag and discards both lists without emitting anything.

Top module: `stacked_coinc_filter`

## Requirements
- R1: During and right after reset, with no input valid, `trk_valid`, `stamp_err`, `inr_ready` and `otr_ready` are all 0.
- R2: When the outer column is greater than the inner column plus REACH (default 1), the inner hit is consumed and no word is emitted for it.
- R3: When the outer column plus REACH is less than the inner column, the outer hit is consumed and no word is emitted for it.
- R4: When the two columns differ by at most REACH, one word is emitted with `trk_eoe`=0, carrying the event stamp, the inner column and the outer column, and both lists advance by one hit.
- R5: After either list delivers its last word, every remaining word of the other list is consumed with no tracklet emitted.
- R6: For an event whose stamps agree, exactly one word with `trk_eoe`=1 follows the last tracklet, with `trk_inner` and `trk_outer` equal to 0. This marker is also sent when there is no tracklet.
- R7: If the two stamp words differ, `stamp_err` is 1 for exactly one cycle, both lists are consumed completely, and no word at all (not even a marker) is emitted for that event.
- R8: While `trk_valid` is 1 and `trk_ready` is 0, the output word is held unchanged and neither input is ready.
- R9: A stamp word is consumed only in a cycle in which both layers present a valid word; a lone stamp is not accepted.
- R10: Columns 0 and 2^COL_W-1 are compared without wraparound (inner 0 against outer 255 drops the inner hit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inr_valid | input | 1 | Inner-layer word valid |
| inr_ready | output | 1 | Inner-layer word accepted |
| inr_word | input | WORD_W | Stamp (first word) or hit column |
| inr_last | input | 1 | Final word of the inner list |
| otr_valid | input | 1 | Outer-layer word valid |
| otr_ready | output | 1 | Outer-layer word accepted |
| otr_word | input | WORD_W | Stamp (first word) or hit column |
| otr_last | input | 1 | Final word of the outer list |
| trk_valid | output | 1 | Output word valid |
| trk_ready | input | 1 | Output word accepted downstream |
| trk_stamp | output | TS_W | Event time stamp |
| trk_inner | output | COL_W | Inner column of the tracklet |
| trk_outer | output | COL_W | Outer column of the tracklet |
| trk_eoe | output | 1 | End-of-event marker word |
| stamp_err | output | 1 | One-cycle pulse on a stamp mismatch |

## Verification
The bound checker checks several properties on every cycle. It checks that a stalled output word holds still and blocks both inputs, that every emitted tracklet lies inside the column window, that a marker word carries zero columns, and that a stamp error is a single-cycle pulse during which nothing is emitted. Some behaviour only the bench's event scenarios can show. This covers which hits get dropped as the merge advances, draining after one list ends, the exact sequence and count of tracklets, the marker after them, and the silent discard of a mismatched event. The same holds for the edge columns and for a lone stamp that must wait for its partner.

// File: rtl/sclf_pkg.sv
// Shared types for the stacked-layer coincidence filter.
package sclf_pkg;
    typedef enum logic [1:0] {
        ST_HEAD,   // waiting for both stamp words
        ST_MERGE,  // stepping through both hit lists
        ST_FLUSH,  // consuming what is left of the lists
        ST_MARK    // sending the end-of-event word
    } sclf_state_e;

    typedef enum logic [1:0] {
        CMP_DROP_INNER,
        CMP_DROP_OUTER,
        CMP_PAIR
    } sclf_cmp_e;
endpackage

// File: rtl/col_window_cmp.sv
// Column window comparator: classifies an inner/outer column pair.
// Assumes unsigned columns; comparisons use two guard bits so no wrap occurs.
module col_window_cmp
    import sclf_pkg::*;
#(
    parameter int COL_W = 8,
    parameter int REACH = 1
) (
    input  logic [COL_W-1:0] inner_col,
    input  logic [COL_W-1:0] outer_col,
    output sclf_cmp_e        verdict
);
    localparam int EXT_W = COL_W + 2;

    logic [EXT_W-1:0] in_x, out_x, reach_x;

    // Widen both columns so that adding the window cannot overflow.
    always_comb begin
        in_x    = {2'b00, inner_col};
        out_x   = {2'b00, outer_col};
        reach_x = EXT_W'(REACH);
    end

    // Pick which hit to drop, or accept the pair.
    always_comb begin
        if (out_x > in_x + reach_x)
            verdict = CMP_DROP_INNER;
        else if (out_x + reach_x < in_x)
            verdict = CMP_DROP_OUTER;
        else
            verdict = CMP_PAIR;
    end
endmodule

// File: rtl/coinc_ctrl.sv
// Merge controller: accepts the stamp words, steps through both sorted lists
// using the comparator verdict, drains leftovers and sends the event marker.
// Assumes each list is stamp word first, hits ascending, last flag on final word.
module coinc_ctrl
    import sclf_pkg::*;
#(
    parameter int TS_W   = 8,
    parameter int COL_W  = 8,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_last,
    input  logic              ou_valid,
    output logic              ou_ready,
    input  logic [WORD_W-1:0] ou_word,
    input  logic              ou_last,
    input  sclf_cmp_e         verdict,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [TS_W-1:0]   m_stamp,
    output logic [COL_W-1:0]  m_inner,
    output logic [COL_W-1:0]  m_outer,
    output logic              m_eoe,
    output logic              m_err
);
    sclf_state_e       state_q;
    logic              skip_q, idone_q, odone_q, err_q;
    logic [TS_W-1:0]   stamp_q;
    logic              both_v, live, in_pop, ou_pop, inner_end, outer_end;

    // Handshake decode per state.
    always_comb begin
        both_v   = in_valid && ou_valid;
        live     = !idone_q && !odone_q;
        in_ready = 1'b0;
        ou_ready = 1'b0;
        m_valid  = 1'b0;
        m_eoe    = 1'b0;
        unique case (state_q)
            ST_HEAD: begin
                in_ready = both_v;
                ou_ready = both_v;
            end
            ST_MERGE: begin
                if (live && both_v) begin
                    unique case (verdict)
                        CMP_DROP_INNER: in_ready = 1'b1;
                        CMP_DROP_OUTER: ou_ready = 1'b1;
                        default: begin
                            m_valid  = 1'b1;
                            in_ready = m_ready;
                            ou_ready = m_ready;
                        end
                    endcase
                end
            end
            ST_FLUSH: begin
                in_ready = !idone_q;
                ou_ready = !odone_q;
            end
            ST_MARK: begin
                m_valid = 1'b1;
                m_eoe   = 1'b1;
            end
            default: ;
        endcase
    end

    // End-of-list tracking including a pop in this cycle.
    always_comb begin
        in_pop    = in_valid && in_ready;
        ou_pop    = ou_valid && ou_ready;
        inner_end = idone_q || (in_pop && in_last);
        outer_end = odone_q || (ou_pop && ou_last);
    end

    // State, stamp and list-done registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HEAD;
            skip_q  <= 1'b0;
            idone_q <= 1'b0;
            odone_q <= 1'b0;
            err_q   <= 1'b0;
            stamp_q <= '0;
        end else begin
            err_q <= 1'b0;
            unique case (state_q)
                ST_HEAD: begin
                    if (both_v) begin
                        stamp_q <= in_word[TS_W-1:0];
                        idone_q <= in_last;
                        odone_q <= ou_last;
                        if (in_word[TS_W-1:0] != ou_word[TS_W-1:0]) begin
                            err_q   <= 1'b1;
                            skip_q  <= 1'b1;
                            state_q <= ST_FLUSH;
                        end else begin
                            skip_q  <= 1'b0;
                            state_q <= ST_MERGE;
                        end
                    end
                end
                ST_MERGE: begin
                    if (!live) begin
                        state_q <= ST_FLUSH;
                    end else begin
                        idone_q <= inner_end;
                        odone_q <= outer_end;
                    end
                end
                ST_FLUSH: begin
                    idone_q <= inner_end;
                    odone_q <= outer_end;
                    if (inner_end && outer_end)
                        state_q <= skip_q ? ST_HEAD : ST_MARK;
                end
                ST_MARK: begin
                    if (m_ready)
                        state_q <= ST_HEAD;
                end
                default: state_q <= ST_HEAD;
            endcase
        end
    end

    // Output word fields; columns only meaningful while merging.
    always_comb begin
        m_stamp = stamp_q;
        m_inner = (state_q == ST_MERGE) ? in_word[COL_W-1:0] : '0;
        m_outer = (state_q == ST_MERGE) ? ou_word[COL_W-1:0] : '0;
        m_err   = err_q;
    end
endmodule

// File: rtl/stacked_coinc_filter.sv
// Top level: stacked-layer column coincidence filter.
// Joins the window comparator and the merge controller. Assumes both layers
// carry the same event order and sorted, ascending hit columns.
module stacked_coinc_filter
    import sclf_pkg::*;
#(
    parameter int TS_W  = 8,
    parameter int COL_W = 8,
    parameter int REACH = 1,
    localparam int WORD_W = (TS_W > COL_W) ? TS_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inr_valid,
    output logic              inr_ready,
    input  logic [WORD_W-1:0] inr_word,
    input  logic              inr_last,
    input  logic              otr_valid,
    output logic              otr_ready,
    input  logic [WORD_W-1:0] otr_word,
    input  logic              otr_last,
    output logic              trk_valid,
    input  logic              trk_ready,
    output logic [TS_W-1:0]   trk_stamp,
    output logic [COL_W-1:0]  trk_inner,
    output logic [COL_W-1:0]  trk_outer,
    output logic              trk_eoe,
    output logic              stamp_err
);
    sclf_cmp_e verdict;

    col_window_cmp #(.COL_W(COL_W), .REACH(REACH)) u_cmp (
        .inner_col (inr_word[COL_W-1:0]),
        .outer_col (otr_word[COL_W-1:0]),
        .verdict   (verdict)
    );

    coinc_ctrl #(.TS_W(TS_W), .COL_W(COL_W), .WORD_W(WORD_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (inr_valid),
        .in_ready (inr_ready),
        .in_word  (inr_word),
        .in_last  (inr_last),
        .ou_valid (otr_valid),
        .ou_ready (otr_ready),
        .ou_word  (otr_word),
        .ou_last  (otr_last),
        .verdict  (verdict),
        .m_valid  (trk_valid),
        .m_ready  (trk_ready),
        .m_stamp  (trk_stamp),
        .m_inner  (trk_inner),
        .m_outer  (trk_outer),
        .m_eoe    (trk_eoe),
        .m_err    (stamp_err)
    );
endmodule

// File: rtl/stacked_coinc_filter_chk.sv
// Port-level property checker for stacked_coinc_filter, attached by bind.
module stacked_coinc_filter_chk #(
    parameter int TS_W  = 8,
    parameter int COL_W = 8,
    parameter int REACH = 1,
    localparam int WORD_W = (TS_W > COL_W) ? TS_W : COL_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inr_valid,
    input logic              inr_ready,
    input logic [WORD_W-1:0] inr_word,
    input logic              inr_last,
    input logic              otr_valid,
    input logic              otr_ready,
    input logic [WORD_W-1:0] otr_word,
    input logic              otr_last,
    input logic              trk_valid,
    input logic              trk_ready,
    input logic [TS_W-1:0]   trk_stamp,
    input logic [COL_W-1:0]  trk_inner,
    input logic [COL_W-1:0]  trk_outer,
    input logic              trk_eoe,
    input logic              stamp_err
);
    logic [COL_W+1:0] in_x, out_x, reach_x;

    // Widened copies of the output columns for the window check.
    always_comb begin
        in_x    = {2'b00, trk_inner};
        out_x   = {2'b00, trk_outer};
        reach_x = (COL_W + 2)'(REACH);
    end

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        trk_valid && !trk_ready |=> trk_valid && $stable(trk_stamp) && $stable(trk_inner) && $stable(trk_outer) && $stable(trk_eoe)); // R8
    AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        trk_valid && !trk_ready |-> !inr_ready && !otr_ready); // R8
    AST_PAIR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        trk_valid && !trk_eoe |-> (out_x <= in_x + reach_x) && (in_x <= out_x + reach_x)); // R4
    AST_MARK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        trk_valid && trk_eoe |-> trk_inner == '0 && trk_outer == '0); // R6
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_err |=> !stamp_err); // R7
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_err |-> !trk_valid); // R7
endmodule

bind stacked_coinc_filter stacked_coinc_filter_chk #(
    .TS_W(TS_W), .COL_W(COL_W), .REACH(REACH)
) u_chk (.*);

// File: tb/stacked_coinc_filter_test.sv
`timescale 1ns/1ps
module stacked_coinc_filter_test;
    localparam int TS_W  = 8;
    localparam int COL_W = 8;
    localparam int NV    = 7;

    typedef struct packed {
        logic [7:0]        ts_i;
        logic [7:0]        ts_o;
        logic [2:0]        ni;
        logic [0:3][7:0]   ih;
        logic [2:0]        no;
        logic [0:3][7:0]   oh;
        logic [2:0]        np;
        logic [0:3][15:0]  pr;   // {inner, outer}
        logic              err;
    } vec_t;

    // Events with their expected tracklets.
    localparam vec_t VECS [0:NV-1] = '{
        // R2/R3/R4: mixed drops and pairs
        '{8'd5, 8'd5, 3'd3, '{8'd3, 8'd10, 8'd20, 8'd0}, 3'd3, '{8'd4, 8'd12, 8'd19, 8'd0},
          3'd2, '{{8'd3, 8'd4}, {8'd20, 8'd19}, 16'd0, 16'd0}, 1'b0},
        // R10: high-edge pair after drops
        '{8'd7, 8'd7, 3'd2, '{8'd0, 8'd255, 8'd0, 8'd0}, 3'd2, '{8'd2, 8'd254, 8'd0, 8'd0},
          3'd1, '{{8'd255, 8'd254}, 16'd0, 16'd0, 16'd0}, 1'b0},
        // R10/R5: 0 against 255 never pairs
        '{8'd8, 8'd8, 3'd1, '{8'd0, 8'd0, 8'd0, 8'd0}, 3'd1, '{8'd255, 8'd0, 8'd0, 8'd0},
          3'd0, '{16'd0, 16'd0, 16'd0, 16'd0}, 1'b0},
        // R7: stamp mismatch
        '{8'd9, 8'd10, 3'd2, '{8'd1, 8'd2, 8'd0, 8'd0}, 3'd1, '{8'd1, 8'd0, 8'd0, 8'd0},
          3'd0, '{16'd0, 16'd0, 16'd0, 16'd0}, 1'b1},
        // R6/R5: empty inner list
        '{8'd3, 8'd3, 3'd0, '{8'd0, 8'd0, 8'd0, 8'd0}, 3'd2, '{8'd5, 8'd6, 8'd0, 8'd0},
          3'd0, '{16'd0, 16'd0, 16'd0, 16'd0}, 1'b0},
        // R5: inner leftovers drained
        '{8'd4, 8'd4, 3'd3, '{8'd5, 8'd5, 8'd6, 8'd0}, 3'd1, '{8'd5, 8'd0, 8'd0, 8'd0},
          3'd1, '{{8'd5, 8'd5}, 16'd0, 16'd0, 16'd0}, 1'b0},
        // R4: four neighbour pairs in a row
        '{8'd6, 8'd6, 3'd4, '{8'd8, 8'd9, 8'd10, 8'd11}, 3'd4, '{8'd9, 8'd10, 8'd11, 8'd12},
          3'd4, '{{8'd8, 8'd9}, {8'd9, 8'd10}, {8'd10, 8'd11}, {8'd11, 8'd12}}, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic inr_valid = 1'b0, inr_last = 1'b0, otr_valid = 1'b0, otr_last = 1'b0;
    logic [7:0] inr_word = '0, otr_word = '0;
    logic inr_ready, otr_ready, trk_valid, trk_eoe, stamp_err;
    logic trk_ready = 1'b1;
    logic [TS_W-1:0] trk_stamp;
    logic [COL_W-1:0] trk_inner, trk_outer;

    int checks = 0;
    int errors = 0;
    int rec_n = 0;
    int err_seen = 0;
    logic [7:0] rec_ts [0:15];
    logic [15:0] rec_pr [0:15];
    logic rec_eoe [0:15];

    always #2.5 clk = ~clk;

    stacked_coinc_filter #(.TS_W(TS_W), .COL_W(COL_W), .REACH(1)) uut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input int k);
        case (k)
            0: return "R2/R3/R4";
            1: return "R10";
            2: return "R10/R5";
            3: return "R7";
            4: return "R6/R5";
            5: return "R5";
            default: return "R4";
        endcase
    endfunction

    // Output monitor: drives a stall pattern and records accepted words.
    initial begin : monitor
        int cyc = 0;
        bit stalled = 1'b0;
        logic [24:0] held = '0;
        forever begin
            @(negedge clk);
            cyc++;
            trk_ready = (cyc % 3) != 0;
            #1;
            if (rst_n) begin
                if (stalled)
                    chk(trk_valid && {trk_stamp, trk_inner, trk_outer, trk_eoe} == held,
                        "R8 stalled word held", int'(trk_valid), 1);
                stalled = trk_valid && !trk_ready;
                held = {trk_stamp, trk_inner, trk_outer, trk_eoe};
                if (stalled)
                    chk(!inr_ready && !otr_ready, "R8 inputs blocked during stall",
                        int'(inr_ready | otr_ready), 0);
                if (trk_valid && trk_ready && rec_n < 16) begin
                    rec_ts[rec_n]  = trk_stamp;
                    rec_pr[rec_n]  = {trk_inner, trk_outer};
                    rec_eoe[rec_n] = trk_eoe;
                    rec_n++;
                end
                if (stamp_err) err_seen++;
            end
        end
    end

    task automatic drive_inner(input vec_t v);
        @(negedge clk);
        for (int k = 0; k <= int'(v.ni); k++) begin
            inr_valid = 1'b1;
            inr_word  = (k == 0) ? v.ts_i : v.ih[k-1];
            inr_last  = (k == int'(v.ni));
            #1;
            while (!inr_ready) begin @(negedge clk); #1; end
            @(negedge clk);
        end
        inr_valid = 1'b0;
        inr_last  = 1'b0;
    endtask

    task automatic drive_outer(input vec_t v);
        @(negedge clk);
        for (int k = 0; k <= int'(v.no); k++) begin
            otr_valid = 1'b1;
            otr_word  = (k == 0) ? v.ts_o : v.oh[k-1];
            otr_last  = (k == int'(v.no));
            #1;
            while (!otr_ready) begin @(negedge clk); #1; end
            @(negedge clk);
        end
        otr_valid = 1'b0;
        otr_last  = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(!trk_valid && !stamp_err, "R1 outputs idle in reset", int'(trk_valid | stamp_err), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!trk_valid && !stamp_err, "R1 outputs idle after reset", int'(trk_valid | stamp_err), 0);
        chk(!inr_ready && !otr_ready, "R1 no ready without valid", int'(inr_ready | otr_ready), 0);

        // R9: a lone inner stamp is not accepted
        @(negedge clk);
        inr_valid = 1'b1;
        inr_word  = 8'd42;
        inr_last  = 1'b1;
        for (int c = 0; c < 3; c++) begin
            #1;
            chk(!inr_ready, "R9 lone stamp held off", int'(inr_ready), 0);
            @(negedge clk);
        end
        inr_valid = 1'b0;
        inr_last  = 1'b0;
        repeat (3) @(negedge clk);
        chk(rec_n == 0 && err_seen == 0, "R9 lone stamp has no effect", rec_n + err_seen, 0);

        // Event table
        for (int k = 0; k < NV; k++) begin
            vec_t v;
            v = VECS[k];
            rec_n = 0;
            err_seen = 0;
            fork
                drive_inner(v);
                drive_outer(v);
            join
            repeat (8) @(negedge clk);
            if (v.err) begin
                chk(err_seen == 1, {tag_of(k), " stamp error pulse"}, err_seen, 1);
                chk(rec_n == 0, {tag_of(k), " no words on mismatch"}, rec_n, 0);
            end else begin
                chk(err_seen == 0, {tag_of(k), " no stamp error"}, err_seen, 0);
                chk(rec_n == int'(v.np) + 1, {tag_of(k), " word count"}, rec_n, int'(v.np) + 1);
                for (int p = 0; p < int'(v.np) && p < rec_n; p++) begin
                    chk(rec_pr[p] == v.pr[p] && !rec_eoe[p], {tag_of(k), " tracklet columns"},
                        int'(rec_pr[p]), int'(v.pr[p]));
                    chk(rec_ts[p] == v.ts_i, {tag_of(k), " tracklet stamp"},
                        int'(rec_ts[p]), int'(v.ts_i));
                end
                if (rec_n == int'(v.np) + 1)
                    chk(rec_eoe[v.np] && rec_pr[v.np] == 16'd0, "R6 end marker",
                        int'(rec_eoe[v.np]), 1);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule